// File: doc/BRIEF.md
# Four-Block Parallel Poly1305 Accumulator Update

This datapath advances a Poly1305 running accumulator across four consecutive 16-byte message blocks in one operation. Four sequential Horner steps become a single weighted sum: the accumulator joins the first block, and each block is multiplied by its own precomputed power of the key, from r^4 for the first block down to r^1 for the last. The modulus 2^130 - 5 is handled inside the multiply: coefficients whose limb position wraps past the top limb are scaled by five and land five positions lower.

Every value is carried as five 26-bit limbs in 32-bit containers, with limb 4 holding the high bits. A caller loads the accumulator, the four key powers and 64 message bytes and pulses `start`. The block keeps one lane multiplier array. It spends one cycle on each block, then one cycle on carry propagation, and then pulses `done` with the new accumulator. The key powers must be computed elsewhere. Tail blocks and tag finalisation are also handled outside this block.

Top module: `poly4_update`

## Requirements
- R1: Block k (k = 0..3) is `msg_in[128k+127:128k]`. Its byte i sits at bits 8i+7:8i of the block, so the bytes are read little-endian. Each block gains an implicit bit of weight 2^128, which is limb 4 bit 24.
- R2: The value of a limb vector is sum(limb_i * 2^(26i)). For the result, val(acc_out) mod (2^130-5) equals (h + m0)*P4 + m1*P3 + m2*P2 + m3*P1 mod (2^130-5). Here h = val(acc_in), mk is block k with its implicit bit, and Pn = val(key_pow[n-1]).
- R3: The accumulator is added only to block 0. No other block receives it.
- R4: When `done` is high, limbs 0, 2, 3 and 4 of `acc_out` are below 2^26 and limb 1 is below 2^27.
- R5: R2 and R4 still hold at the extreme inputs: every input limb at 2^26-1, accumulator limb 1 up to 2^27-1, and message bytes all 0xFF.
- R6: `done` is high for exactly one cycle. It is sampled high six rising edges after the edge that accepted `start`.
- R7: A `start` that arrives while an update is in progress is ignored, and the result reflects the inputs that were accepted first.
- R8: `acc_out` changes only at the edge that raises `done`. It holds its value until the next update completes.
- R9: After reset, `done` is low and `acc_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an update (accepted only when idle) |
| acc_in | input | 5x32 | Running accumulator, five 26-bit limbs |
| key_pow | input | 4x5x32 | Key powers; index n holds r^(n+1) |
| msg_in | input | 512 | Four 16-byte message blocks |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | 5x32 | Updated accumulator limbs |

## Verification
Directed patterns each isolate one factor:
- Key powers of one with a zero message expose the implicit 2^128 bit.
- A single nonzero byte locates the byte and block order.
- A single nonzero key power shows which block receives the accumulator and which power pairs with which block.

Saturated inputs probe the 64-bit partial-sum headroom and the limb bounds. Seeded random keys with derived powers, random messages and random non-canonical accumulators cover the general sum. One run fires a second `start` mid-update to check that the accepted inputs are kept.

// File: rtl/poly4_pkg.sv
package poly4_pkg;
    localparam int LIMB_W    = 26;
    localparam int NLIMB     = 5;
    localparam int NLANE     = 4;
    localparam int BLK_BYTES = 16;
    localparam int PORT_W    = 32;
    localparam int SUM_W     = 64;
    localparam int BLK_W     = BLK_BYTES * 8;
    localparam int MSG_W     = NLANE * BLK_W;
    localparam int TOP_LO    = (NLIMB - 1) * LIMB_W;
    localparam int HIBIT_POS = BLK_W - TOP_LO;
    localparam int LANE_W    = $clog2(NLANE);

    typedef logic [PORT_W-1:0] limb_t;
    typedef limb_t [NLIMB-1:0] vec_t;
    typedef logic [SUM_W-1:0]  psum_t;
    typedef psum_t [NLIMB-1:0] psum_vec_t;

    typedef enum logic [1:0] {ST_IDLE, ST_MAC, ST_FIN} state_e;

    localparam psum_t LIMB_MASK = (psum_t'(1) << LIMB_W) - psum_t'(1);

    function automatic limb_t times5(limb_t x);
        return (x << 2) + x;
    endfunction

    function automatic psum_t wide5(psum_t x);
        return (x << 2) + x;
    endfunction
endpackage

// File: rtl/poly4_blk_split.sv
module poly4_blk_split
    import poly4_pkg::*;
(
    input  logic [BLK_W-1:0] blk,
    output vec_t             limbs
);
    for (genvar i = 0; i < NLIMB - 1; i++) begin : g_low
        assign limbs[i] = limb_t'(blk[i*LIMB_W +: LIMB_W]);
    end
    assign limbs[NLIMB-1] = limb_t'(blk[BLK_W-1:TOP_LO]) | (limb_t'(1) << HIBIT_POS);
endmodule

// File: rtl/poly4_lane_mac.sv
module poly4_lane_mac
    import poly4_pkg::*;
(
    input  vec_t      m,
    input  vec_t      r,
    output psum_vec_t d
);
    vec_t  r5;
    psum_t term [NLIMB][NLIMB];

    for (genvar i = 0; i < NLIMB; i++) begin : g_scale
        assign r5[i] = times5(r[i]);
    end

    for (genvar j = 0; j < NLIMB; j++) begin : g_out
        for (genvar i = 0; i < NLIMB; i++) begin : g_in
            if (i <= j) begin : g_direct
                assign term[j][i] = psum_t'(m[i]) * psum_t'(r[j-i]);
            end else begin : g_wrap
                assign term[j][i] = psum_t'(m[i]) * psum_t'(r5[j-i+NLIMB]);
            end
        end
    end

    always_comb begin
        for (int j = 0; j < NLIMB; j++) begin
            d[j] = '0;
            for (int i = 0; i < NLIMB; i++) begin
                d[j] = d[j] + term[j][i];
            end
        end
    end
endmodule

// File: rtl/poly4_carry.sv
module poly4_carry
    import poly4_pkg::*;
(
    input  psum_vec_t d,
    output vec_t      h
);
    psum_vec_t t;
    psum_t     c;

    always_comb begin
        t = d;
        for (int i = 0; i < NLIMB - 1; i++) begin
            c        = t[i] >> LIMB_W;
            t[i]     = t[i] & LIMB_MASK;
            t[i+1]   = t[i+1] + c;
        end
        c          = t[NLIMB-1] >> LIMB_W;
        t[NLIMB-1] = t[NLIMB-1] & LIMB_MASK;
        t[0]       = t[0] + wide5(c);
        c          = t[0] >> LIMB_W;
        t[0]       = t[0] & LIMB_MASK;
        t[1]       = t[1] + c;
        for (int i = 0; i < NLIMB; i++) begin
            h[i] = limb_t'(t[i]);
        end
    end
endmodule

// File: rtl/poly4_update.sv
module poly4_update
    import poly4_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               start,
    input  logic [NLIMB-1:0][PORT_W-1:0]       acc_in,
    input  logic [NLANE-1:0][NLIMB-1:0][PORT_W-1:0] key_pow,
    input  logic [MSG_W-1:0]                   msg_in,
    output logic                               done,
    output logic [NLIMB-1:0][PORT_W-1:0]       acc_out
);
    state_e                  st;
    logic [LANE_W-1:0]       lane;
    vec_t [NLANE-1:0]        blk_l;
    vec_t [NLANE-1:0]        mreg;
    vec_t [NLANE-1:0]        rreg;
    vec_t                    first_l;
    psum_vec_t               sum;
    psum_vec_t               lane_d;
    vec_t                    fin;

    for (genvar k = 0; k < NLANE; k++) begin : g_split
        poly4_blk_split u_split (
            .blk   (msg_in[k*BLK_W +: BLK_W]),
            .limbs (blk_l[k])
        );
    end

    for (genvar i = 0; i < NLIMB; i++) begin : g_fold
        assign first_l[i] = blk_l[0][i] + acc_in[i];
    end

    poly4_lane_mac u_mac (
        .m (mreg[lane]),
        .r (rreg[lane]),
        .d (lane_d)
    );

    poly4_carry u_carry (
        .d (sum),
        .h (fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            lane    <= '0;
            mreg    <= '0;
            rreg    <= '0;
            sum     <= '0;
            done    <= 1'b0;
            acc_out <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        for (int k = 0; k < NLANE; k++) begin
                            mreg[k] <= (k == 0) ? first_l : blk_l[k];
                            rreg[k] <= key_pow[NLANE-1-k];
                        end
                        sum  <= '0;
                        lane <= '0;
                        st   <= ST_MAC;
                    end
                end
                ST_MAC: begin
                    for (int i = 0; i < NLIMB; i++) begin
                        sum[i] <= sum[i] + lane_d[i];
                    end
                    lane <= lane + LANE_W'(1);
                    if (lane == LANE_W'(NLANE - 1)) begin
                        st <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    acc_out <= fin;
                    done    <= 1'b1;
                    st      <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/poly4_update_chk.sv
module poly4_update_chk
    import poly4_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic                         start,
    input logic                         done,
    input logic [NLIMB-1:0][PORT_W-1:0] acc_out
);
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start, 6));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(acc_out));

    // R4
    limb_bound_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (acc_out[0] < 32'h0400_0000 && acc_out[1] < 32'h0800_0000 &&
                  acc_out[2] < 32'h0400_0000 && acc_out[3] < 32'h0400_0000 &&
                  acc_out[4] < 32'h0400_0000));
endmodule

bind poly4_update poly4_update_chk u_chk (.*);

// File: tb/test_poly4_update.sv
`timescale 1ns/1ps
module test_poly4_update;
    typedef logic [299:0] big_t;
    localparam big_t PMOD = (big_t'(1) << 130) - big_t'(5);
    localparam big_t HIB  = big_t'(1) << 128;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic                       start = 1'b0;
    logic [4:0][31:0]           acc_in = '0;
    logic [3:0][4:0][31:0]      key_pow = '0;
    logic [511:0]               msg_in = '0;
    logic                       done;
    logic [4:0][31:0]           acc_out;

    int checks = 0;
    int fails  = 0;

    poly4_update i_poly4_update (
        .clk(clk), .rst(rst), .start(start), .acc_in(acc_in),
        .key_pow(key_pow), .msg_in(msg_in), .done(done), .acc_out(acc_out)
    );

    always #10 clk = ~clk;

    function automatic big_t vval(logic [4:0][31:0] v);
        big_t s = '0;
        for (int i = 0; i < 5; i++) s = s + (big_t'(v[i]) << (26 * i));
        return s;
    endfunction

    function automatic logic [4:0][31:0] split(big_t x);
        logic [4:0][31:0] v;
        for (int i = 0; i < 5; i++) v[i] = 32'(x[26*i +: 26]);
        return v;
    endfunction

    function automatic big_t model();
        big_t h = vval(acc_in);
        big_t m [4];
        big_t e;
        for (int k = 0; k < 4; k++) m[k] = big_t'(msg_in[128*k +: 128]) + HIB;
        e = (h + m[0]) * vval(key_pow[3]) + m[1] * vval(key_pow[2])
          + m[2] * vval(key_pow[1]) + m[3] * vval(key_pow[0]);
        return e % PMOD;
    endfunction

    task automatic chk(input bit ok, input string req, input big_t act, input big_t exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic set_pows(input big_t p1, input big_t p2, input big_t p3, input big_t p4);
        key_pow[0] = split(p1);
        key_pow[1] = split(p2);
        key_pow[2] = split(p3);
        key_pow[3] = split(p4);
    endtask

    task automatic run_op(input string req, input bit poke);
        big_t exp = model();
        logic [4:0][31:0] held;
        int n;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
            if (poke && n == 2) begin
                acc_in = ~acc_in;
                msg_in = ~msg_in;
                start = 1'b1;
            end
            if (n == 3) start = 1'b0;
        end
        chk(n == 6, "R6 latency", big_t'(n), big_t'(6));
        chk((vval(acc_out) % PMOD) == exp, req, vval(acc_out) % PMOD, exp);
        chk(acc_out[0] < 32'h0400_0000 && acc_out[1] < 32'h0800_0000 &&
            acc_out[2] < 32'h0400_0000 && acc_out[3] < 32'h0400_0000 &&
            acc_out[4] < 32'h0400_0000, "R4 limb bounds", vval(acc_out), exp);
        held = acc_out;
        @(negedge clk);
        chk(!done, "R6 single-cycle done", big_t'(done), big_t'(0));
        repeat (3) @(negedge clk);
        chk(acc_out == held, "R8 output hold", vval(acc_out), vval(held));
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        big_t r1, r2, r3, r4;
        void'($urandom(32'h51D3_0F11));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk(!done && acc_out == '0, "R9 reset state", vval(acc_out), '0);

        // R1: implicit bit only, all powers one
        set_pows(1, 1, 1, 1);
        acc_in = '0; msg_in = '0;
        run_op("R1 implicit bit", 1'b0);
        chk((vval(acc_out) % PMOD) == big_t'(5), "R1 value five", vval(acc_out) % PMOD, 5);

        // R1: byte order, single byte 0 of block 3
        msg_in = '0; msg_in[384] = 1'b1;
        run_op("R1 byte order", 1'b0);

        // R3: only r^4 nonzero, accumulator joins block 0
        set_pows(0, 0, 0, 1);
        acc_in = split(big_t'(128'h0123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6978));
        for (int w = 0; w < 16; w++) msg_in[32*w +: 32] = $urandom;
        run_op("R3 accumulator into block 0", 1'b0);

        // R2: only r^1 nonzero pairs with last block
        set_pows(2, 0, 0, 0);
        run_op("R2 last block with r^1", 1'b0);

        // R5: saturated inputs
        for (int p = 0; p < 4; p++)
            for (int i = 0; i < 5; i++) key_pow[p][i] = 32'h03FF_FFFF;
        for (int i = 0; i < 5; i++) acc_in[i] = 32'h03FF_FFFF;
        acc_in[1] = 32'h07FF_FFFF;
        msg_in = '1;
        run_op("R5 worst case", 1'b0);

        // R2 random, R7 with mid-update start
        for (int t = 0; t < 40; t++) begin
            r1 = big_t'({$urandom, $urandom, $urandom, $urandom})
               & big_t'(128'h0FFF_FFFC_0FFF_FFFC_0FFF_FFFC_0FFF_FFFF);
            r2 = (r1 * r1) % PMOD;
            r3 = (r2 * r1) % PMOD;
            r4 = (r3 * r1) % PMOD;
            set_pows(r1, r2, r3, r4);
            for (int w = 0; w < 16; w++) msg_in[32*w +: 32] = $urandom;
            for (int i = 0; i < 5; i++) acc_in[i] = $urandom & 32'h03FF_FFFF;
            if (t % 2 == 1) acc_in[1] = $urandom & 32'h07FF_FFFF;
            if (t % 8 == 3) run_op("R7 busy start ignored", 1'b1);
            else            run_op("R2 random sum", 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule